// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus master that works through a ring of transmit descriptors held in memory. Each descriptor takes 16 bytes. The first word is status, the second is control and length, the third is the buffer address and the fourth is reserved for a next pointer, which the engine never reads. The host fills in descriptors and hands each one over by setting its ownership bit. It then pulses a poll-demand input. The engine reads each descriptor it owns and fetches the buffer word by word. It sends the bytes on a valid/ready byte stream. It then writes a status word back that returns ownership to the host.

A descriptor flagged as a setup frame holds address-filter contents. Its bytes go to a separate filter port and never reach the wire. When the engine reaches a descriptor it does not own, it stops and waits for the next poll demand. A poll that arrives while the engine is still reading a status word is remembered, so the host cannot lose an update to that race. The ring position is kept as an offset from a programmable base address.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset the engine is suspended. It makes no memory request and drives neither byte port as valid until the first poll. Its first fetch is the status word at `ring_base`.
- R2: A memory request keeps its address, direction and data steady until `mem_ack`. Only one request is outstanding at a time. A 5-byte frame followed by an unowned descriptor costs exactly 7 transfers.
- R3: If the status word has bit 31 (ownership) clear, the engine suspends at that descriptor and makes no further requests, even if the descriptor later becomes owned. A poll re-reads the same descriptor.
- R4: For an owned descriptor, the engine reads control at offset 4 and the buffer address at offset 8. It then sends `control[LEN_W-1:0]` bytes from the word-aligned buffer, least significant byte of each word first. Buffer address bits 1:0 are ignored.
- R5: `tx_last` is high on the final byte of a buffer if and only if control bit 30 is set. While `tx_valid` is high and `tx_ready` is low, the data and last flag stay unchanged.
- R6: A normal descriptor that completes cleanly has its status word rewritten as 0x00000000, which returns ownership.
- R7: After the write-back, the engine moves to ring offset 0 if control bit 25 is set, and otherwise advances 16 bytes. It goes straight on to the next descriptor without waiting for a poll.
- R8: A descriptor with length zero sends no bytes. Its status is written as 0x00008000, with bit 15 as the error flag.
- R9: A descriptor with control bit 27 set and length equal to `SETUP_LEN` sends its bytes on the filter port only. `filt_last` is high on the final byte, and the status is written as 0x7FFFFFFF.
- R10: A descriptor with bit 27 set and any other length sends no bytes on either port. Its status is written as 0x00008000.
- R11: A poll that arrives while a status read is outstanding is remembered. If that read finds the descriptor unowned, the engine reads the status word once more before it suspends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| poll | input | 1 | One-cycle poll-demand pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Wire byte valid |
| tx_ready | input | 1 | Wire byte accepted |
| tx_data | output | 8 | Wire byte |
| tx_last | output | 1 | Final byte of a frame |
| filt_valid | output | 1 | Filter byte valid (always accepted) |
| filt_data | output | 8 | Filter byte |
| filt_last | output | 1 | Final byte of the setup frame |

## Verification
The bench builds the engine with AW=16, LEN_W=11 and SETUP_LEN=192, and places the ring at 0x40 in a 1 KB memory model. With a 4-byte word, the frame lengths 3, 5, 6 and 9 end on partial words. A full 192-byte setup frame fits next to the normal buffers. A three-descriptor ring wraps within a single poll. Random backpressure on `tx_ready` keeps bytes waiting at the port. A poll injected during an outstanding status read exercises the remembered-poll path.

// File: rtl/tde_pkg.sv
package tde_pkg;
   localparam int DW          = 32;
   localparam int OWN_BIT     = 31;
   localparam int LS_BIT      = 30;
   localparam int SET_BIT     = 27;
   localparam int EOR_BIT     = 25;
   localparam int CTL_OFS     = 4;
   localparam int BUF_OFS     = 8;
   localparam int DESC_STRIDE = 16;
   localparam logic [DW-1:0] ST_DONE     = 32'h0000_0000;
   localparam logic [DW-1:0] ST_ERR      = 32'h0000_8000;
   localparam logic [DW-1:0] ST_SETUP_OK = 32'h7FFF_FFFF;

   typedef enum logic [2:0] {
      S_SUSP, S_STS, S_CTL, S_BUF, S_DAT, S_STRM, S_WB
   } eng_state_t;
endpackage

// File: rtl/tde_byte_unpack.sv
module tde_byte_unpack #(
   parameter int BYTES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld,
   input  logic [8*BYTES-1:0] ld_word,
   input  logic [$clog2(BYTES+1)-1:0] ld_cnt,
   input  logic               ld_fin,
   input  logic               ready_i,
   output logic               valid_o,
   output logic [7:0]         data_o,
   output logic               last_o
);
   localparam int CNT_W = $clog2(BYTES + 1);
   localparam int IDX_W = $clog2(BYTES);

   logic [8*BYTES-1:0] word_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic               fin_q;
   logic [7:0]         lane [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane[g] = word_q[8*g +: 8];
   end

   assign valid_o = (cnt_q != '0);
   assign data_o  = lane[idx_q];
   assign last_o  = fin_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         fin_q  <= 1'b0;
      end else if (ld) begin
         word_q <= ld_word;
         cnt_q  <= ld_cnt;
         idx_q  <= '0;
         fin_q  <= ld_fin;
      end else if (valid_o && ready_i) begin
         cnt_q  <= cnt_q - CNT_W'(1);
         idx_q  <= idx_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/tde_route.sv
module tde_route (
   input  logic       sel_filt,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic [7:0] tx_data,
   output logic       tx_last,
   output logic       filt_valid,
   output logic [7:0] filt_data,
   output logic       filt_last
);
   assign tx_valid   = in_valid && !sel_filt;
   assign tx_data    = in_data;
   assign tx_last    = in_last && !sel_filt;
   assign filt_valid = in_valid && sel_filt;
   assign filt_data  = in_data;
   assign filt_last  = in_last && sel_filt;
   assign in_ready   = sel_filt ? 1'b1 : tx_ready;
endmodule

// File: rtl/tde_ring_ctrl.sv
module tde_ring_ctrl
   import tde_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 11,
   parameter int SETUP_LEN = 192,
   parameter int BYTES     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ring_base,
   input  logic          poll,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          ld_o,
   output logic [DW-1:0] ld_word_o,
   output logic [$clog2(BYTES+1)-1:0] ld_cnt_o,
   output logic          ld_fin_o,
   output logic          to_filt_o,
   input  logic          drain_i
);
   localparam int CNT_W = $clog2(BYTES + 1);

   eng_state_t       st_q;
   logic [AW-1:0]    off_q, ptr_q;
   logic [LEN_W-1:0] rem_q;
   logic             set_q, ls_q, eor_q, err_q, pend_q;

   logic [LEN_W-1:0] len_w;
   logic             bad_len, chunk_full, chunk_last;
   logic [CNT_W-1:0] chunk_n;

   assign len_w      = mem_rdata[LEN_W-1:0];
   assign bad_len    = (len_w == '0) ||
                       (mem_rdata[SET_BIT] && (len_w != LEN_W'(SETUP_LEN)));
   assign chunk_full = (rem_q >= LEN_W'(BYTES));
   assign chunk_last = (rem_q <= LEN_W'(BYTES));
   assign chunk_n    = chunk_full ? CNT_W'(BYTES) : rem_q[CNT_W-1:0];

   always_comb begin
      unique case (st_q)
         S_CTL:   mem_addr = ring_base + off_q + AW'(CTL_OFS);
         S_BUF:   mem_addr = ring_base + off_q + AW'(BUF_OFS);
         S_DAT:   mem_addr = ptr_q;
         default: mem_addr = ring_base + off_q;
      endcase
   end

   assign mem_req   = (st_q != S_SUSP) && (st_q != S_STRM);
   assign mem_we    = (st_q == S_WB);
   assign mem_wdata = err_q ? ST_ERR : (set_q ? ST_SETUP_OK : ST_DONE);

   assign ld_o      = (st_q == S_DAT) && mem_ack;
   assign ld_word_o = mem_rdata;
   assign ld_cnt_o  = chunk_n;
   assign ld_fin_o  = chunk_last && (set_q || ls_q);
   assign to_filt_o = set_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_SUSP;
         off_q  <= '0;
         ptr_q  <= '0;
         rem_q  <= '0;
         set_q  <= 1'b0;
         ls_q   <= 1'b0;
         eor_q  <= 1'b0;
         err_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (poll) pend_q <= 1'b1;
         unique case (st_q)
            S_SUSP: if (poll) begin
               st_q   <= S_STS;
               pend_q <= 1'b0;
            end
            S_STS: if (mem_ack) begin
               if (mem_rdata[OWN_BIT]) begin
                  st_q <= S_CTL;
               end else if (pend_q || poll) begin
                  st_q   <= S_STS;
                  pend_q <= 1'b0;
               end else begin
                  st_q <= S_SUSP;
               end
            end
            S_CTL: if (mem_ack) begin
               set_q <= mem_rdata[SET_BIT];
               ls_q  <= mem_rdata[LS_BIT];
               eor_q <= mem_rdata[EOR_BIT];
               rem_q <= len_w;
               err_q <= bad_len;
               st_q  <= bad_len ? S_WB : S_BUF;
            end
            S_BUF: if (mem_ack) begin
               ptr_q <= {mem_rdata[AW-1:2], 2'b00};
               st_q  <= S_DAT;
            end
            S_DAT: if (mem_ack) begin
               ptr_q <= ptr_q + AW'(BYTES);
               rem_q <= rem_q - LEN_W'(chunk_n);
               st_q  <= S_STRM;
            end
            S_STRM: if (drain_i) begin
               st_q <= (rem_q == '0) ? S_WB : S_DAT;
            end
            S_WB: if (mem_ack) begin
               off_q  <= eor_q ? '0 : off_q + AW'(DESC_STRIDE);
               err_q  <= 1'b0;
               st_q   <= S_STS;
               pend_q <= poll;
            end
            default: st_q <= S_SUSP;
         endcase
      end
   end

   // R2: request held steady until acknowledged
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R3: an unowned status with no poll pending leaves the bus idle
   a_r3_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_STS) && mem_ack && !mem_rdata[OWN_BIT] && !pend_q && !poll
      |=> !mem_req);

   // R8: zero length goes straight to the status write
   a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CTL) && mem_ack && (mem_rdata[LEN_W-1:0] == '0)
      |=> mem_req && mem_we);
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
   import tde_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 11,
   parameter int SETUP_LEN = 192
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ring_base,
   input  logic          poll,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          filt_valid,
   output logic [7:0]    filt_data,
   output logic          filt_last
);
   localparam int BYTES = DW / 8;
   localparam int CNT_W = $clog2(BYTES + 1);

   if (AW < 8 || AW > DW) begin : g_bad_aw
      $error("AW out of range");
   end
   if (LEN_W <= CNT_W || LEN_W > EOR_BIT) begin : g_bad_len
      $error("LEN_W out of range");
   end
   if (SETUP_LEN < 1 || SETUP_LEN >= (1 << LEN_W)) begin : g_bad_setup
      $error("SETUP_LEN does not fit LEN_W");
   end

   logic             ld, ld_fin, to_filt;
   logic [DW-1:0]    ld_word;
   logic [CNT_W-1:0] ld_cnt;
   logic             u_valid, u_last, u_ready;
   logic [7:0]       u_data;

   tde_ring_ctrl #(
      .AW(AW), .LEN_W(LEN_W), .SETUP_LEN(SETUP_LEN), .BYTES(BYTES)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ld_o(ld), .ld_word_o(ld_word), .ld_cnt_o(ld_cnt), .ld_fin_o(ld_fin),
      .to_filt_o(to_filt), .drain_i(!u_valid)
   );

   tde_byte_unpack #(.BYTES(BYTES)) unpack_i (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt),
      .ld_fin(ld_fin), .ready_i(u_ready), .valid_o(u_valid),
      .data_o(u_data), .last_o(u_last)
   );

   tde_route route_i (
      .sel_filt(to_filt), .in_valid(u_valid), .in_data(u_data),
      .in_last(u_last), .in_ready(u_ready),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .filt_valid(filt_valid), .filt_data(filt_data),
      .filt_last(filt_last)
   );

   // R4: no memory traffic while bytes are being delivered
   a_r4_quiet_stream: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid || filt_valid) |-> !mem_req);

   // R5: a stalled wire byte holds
   a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: tb/tx_desc_engine_tb_top.sv
module tx_desc_engine_tb_top;
   localparam int AW = 16;
   localparam logic [31:0] OWN = 32'h8000_0000;
   localparam logic [31:0] LS  = 32'h4000_0000;
   localparam logic [31:0] FS  = 32'h2000_0000;
   localparam logic [31:0] SET = 32'h0800_0000;
   localparam logic [31:0] EOR = 32'h0200_0000;

   logic clk = 1'b0, rst_n = 1'b0, poll = 1'b0, tx_ready = 1'b0;
   logic [AW-1:0] ring_base = 16'h0040;
   logic mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata = '0;
   logic tx_valid, tx_last, filt_valid, filt_last;
   logic [7:0] tx_data, filt_data;

   logic [31:0] mem [256];
   logic [8:0] exp_tx [$];
   logic [8:0] exp_filt [$];
   int checks = 0, errors = 0, nreq = 0;

   always #5 clk = ~clk;

   tx_desc_engine #(.AW(AW), .LEN_W(11), .SETUP_LEN(192)) dut_i (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .filt_valid(filt_valid), .filt_data(filt_data),
      .filt_last(filt_last)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // memory model: ack one cycle after the request is seen
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         end
         if (mem_req && mem_ack) nreq++;
      end
   end

   // backpressure
   initial begin
      logic [15:0] lf = 16'hACE1;
      forever begin
         @(posedge clk);
         #1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         tx_ready = lf[0] | lf[3];
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      logic [8:0] e;
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) chk(0, "R4 unexpected tx byte", {tx_last, tx_data}, 0);
            else begin
               e = exp_tx.pop_front();
               chk({tx_last, tx_data} == e, "R4/R5 tx byte", {tx_last, tx_data}, e);
            end
         end
         if (filt_valid) begin
            if (exp_filt.size() == 0) chk(0, "R9 unexpected filter byte", {filt_last, filt_data}, 0);
            else begin
               e = exp_filt.pop_front();
               chk({filt_last, filt_data} == e, "R9 filter byte", {filt_last, filt_data}, e);
            end
         end
      end
   end

   function automatic int dw(input int n);
      return 16 + 4 * n;
   endfunction

   task automatic put_desc(input int n, input bit own, input logic [31:0] ctl,
                           input logic [31:0] buf_a);
      mem[dw(n)]     = own ? OWN : 32'h0;
      mem[dw(n) + 1] = ctl;
      mem[dw(n) + 2] = buf_a;
   endtask

   task automatic push_bytes(input int ba, input int len, input bit lastf, input bit filt);
      for (int k = 0; k < len; k++) begin
         logic [31:0] w = mem[((ba + k) >> 2) & 255];
         logic [7:0] b = w[8*((ba + k) % 4) +: 8];
         logic [8:0] item = {(k == len - 1) && lastf, b};
         if (filt) exp_filt.push_back(item);
         else exp_tx.push_back(item);
      end
   endtask

   task automatic do_poll();
      @(posedge clk); #1 poll = 1'b1;
      @(posedge clk); #1 poll = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 30) begin
         @(negedge clk);
         if (!mem_req && !tx_valid && !filt_valid) q++;
         else q = 0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 64; i < 192; i++) mem[i] = (i * 32'h0101_0101) ^ 32'hA5C3_0F00;
      for (int i = 192; i < 240; i++) mem[i] = 32'hFFFF_FFFF;
      mem[192] = 32'hFFFF_3412;
      mem[193] = 32'hFFFF_7856;
      mem[194] = 32'hFFFF_BC9A;

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (20) begin
         @(negedge clk);
         chk(!mem_req && !tx_valid && !filt_valid, "R1 idle after reset",
             {mem_req, tx_valid, filt_valid}, 0);
      end

      // R4 R6: single frame, then unowned neighbour
      put_desc(0, 1, LS | FS | 32'd5, 32'h0000_0100);
      put_desc(1, 0, 32'h0, 32'h0);
      push_bytes(32'h100, 5, 1, 0);
      n0 = nreq;
      do_poll();
      wait_quiet();
      chk(mem[dw(0)] == 32'h0, "R6 status written back", mem[dw(0)], 0);
      chk(nreq - n0 == 7, "R2 transfer count", nreq - n0, 7);
      chk(exp_tx.size() == 0, "R4 all bytes sent", exp_tx.size(), 0);

      // R3: poll on unowned, then own without poll
      n0 = nreq;
      do_poll();
      wait_quiet();
      chk(nreq - n0 == 1, "R3 single re-read", nreq - n0, 1);
      put_desc(1, 1, FS | 32'd6, 32'h0000_0200);
      repeat (50) @(negedge clk);
      chk(nreq - n0 == 1, "R3 no fetch without poll", nreq - n0, 1);

      // R5 R7: multi-descriptor frame, wrap at end of ring
      put_desc(2, 1, LS | EOR | 32'd3, 32'h0000_0243);
      put_desc(0, 1, LS | FS | 32'd9, 32'h0000_0280);
      push_bytes(32'h200, 6, 0, 0);
      push_bytes(32'h240, 3, 1, 0);
      push_bytes(32'h280, 9, 1, 0);
      do_poll();
      wait_quiet();
      chk(exp_tx.size() == 0, "R7 wrap reached descriptor 0", exp_tx.size(), 0);
      chk(mem[dw(1)] == 0 && mem[dw(2)] == 0 && mem[dw(0)] == 0,
          "R7 all statuses returned", mem[dw(2)], 0);

      // R8: zero length
      put_desc(1, 1, LS | FS, 32'h0000_0100);
      do_poll();
      wait_quiet();
      chk(mem[dw(1)] == 32'h0000_8000, "R8 zero length error", mem[dw(1)], 32'h8000);

      // R9: setup frame to filter
      put_desc(2, 1, SET | EOR | 32'd192, 32'h0000_0300);
      push_bytes(32'h300, 192, 1, 1);
      do_poll();
      wait_quiet();
      chk(mem[dw(2)] == 32'h7FFF_FFFF, "R9 setup status", mem[dw(2)], 32'h7FFF_FFFF);
      chk(exp_filt.size() == 0, "R9 all filter bytes", exp_filt.size(), 0);

      // R10: setup frame with wrong length
      put_desc(0, 1, SET | LS | 32'd64, 32'h0000_0300);
      do_poll();
      wait_quiet();
      chk(mem[dw(0)] == 32'h0000_8000, "R10 bad setup error", mem[dw(0)], 32'h8000);

      // R11: poll during outstanding status read
      mem[dw(1)]     = 32'h0000_8000;
      mem[dw(1) + 1] = LS | FS | 32'd4;
      mem[dw(1) + 2] = 32'h0000_0100;
      push_bytes(32'h100, 4, 1, 0);
      do_poll();
      @(negedge clk);
      chk(mem_req && !mem_we, "R11 status read pending", mem_req, 1);
      poll = 1'b1;
      @(posedge clk);
      #1 poll = 1'b0;
      mem[dw(1)] = OWN;
      wait_quiet();
      chk(exp_tx.size() == 0, "R11 frame sent after re-read", exp_tx.size(), 0);
      chk(mem[dw(1)] == 32'h0, "R11 status returned", mem[dw(1)], 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule